// File: doc/BRIEF.md
# Coarse-Fine Integer Motion Search Sequencer

This block steps through the integer motion-vector candidates for one 16x16 macroblock and keeps the best match found so far. An external distortion unit scores each candidate and returns the cost. The sequencer does not fetch pixels and does no arithmetic on them.

The block works in two passes, started by a one-cycle `start` pulse. The coarse pass scores only candidates whose column and row offsets are both even. It covers the whole search window and yields a coarse vector. The fine pass then scores the remaining positions, those with at least one odd coordinate, over the full vertical range. It keeps only the columns that fall inside one of two 2*BAND-wide horizontal bands: one centred on column zero and one centred on the coarse vector's column. Each candidate goes out on a valid/ready handshake. Only one candidate is outstanding at any time, and its cost comes back on `cost_valid`. When the last fine cost has been taken in, the best vector and its cost are final and `done` rises.

Top module: `coarse_fine_search`

## Requirements
- R1: The coarse pass issues every position (x, y) with x and y both even, for x in [-HALF_W, HALF_W-1] and y in [-HALF_H, HALF_H-1]. The order is rows from the lowest y upward, and columns from the lowest x upward within each row.
- R2: The coarse vector is the coarse candidate with the smallest cost. On equal costs, the earliest-issued coarse candidate is the coarse vector.
- R3: After the coarse pass, the fine pass issues positions in the same row-then-column order. The rows run over the full range [-HALF_H, HALF_H-1]. A fine position never has both x and y even.
- R4: A fine position is issued only if -BAND <= x < BAND, or -BAND <= x - cx < BAND, where cx is the coarse vector's column. Positions that fail this rule cost no cycle of the sequencer.
- R5: Where the two bands overlap, every position is issued exactly once.
- R6: The best vector is replaced only when a returned cost is strictly smaller than the best cost. On equal costs, the earliest candidate across both passes is kept.
- R7: `cand_valid` stays high, with `cand_x` and `cand_y` unchanged, until `cand_ready` is high. After a handshake, no new candidate is offered until a cost has returned. A `cost_valid` pulse that arrives while no candidate is outstanding is ignored.
- R8: A `start` accepted while the block is idle clears `done` and sets the best cost to all ones. `done` goes high in the cycle after the last fine cost is accepted, and it stays high until the next start.
- R9: After reset, `cand_valid` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Starts a search for one macroblock when the block is idle |
| cand_valid | output | 1 | A candidate is offered |
| cand_ready | input | 1 | The cost unit accepts the candidate |
| cand_x | output | XW | Candidate column offset, signed |
| cand_y | output | YW | Candidate row offset, signed |
| cost_valid | input | 1 | A cost is returned for the outstanding candidate |
| cost | input | CW | Distortion cost of the outstanding candidate |
| best_x | output | XW | Best column offset so far, signed |
| best_y | output | YW | Best row offset so far, signed |
| best_cost | output | CW | Cost of the best vector |
| done | output | 1 | The search is complete and the best outputs are final |

## Verification
The hardest case to reach is the one where the band around the coarse vector lies against the window edge, or overlaps the band around zero. Only the cost values decide where the coarse vector lands, so the bench uses a small window and feeds cost surfaces that put the minimum in the middle, at the left edge, near the right edge and on a flat (tied) surface. It checks the full issued sequence against an order computed in the bench. Stalls on `cand_ready`, cost delays of varying length and stray cost pulses during stalls drive the handshake into its waiting states.

// File: rtl/coarse_fine_search.sv
module coarse_fine_search #(
  parameter int HALF_W = 96,
  parameter int HALF_H = 64,
  parameter int BAND   = 32,
  parameter int CW     = 16,
  localparam int XW = $clog2(HALF_W + BAND) + 2,
  localparam int YW = $clog2(HALF_H) + 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  output logic                 cand_valid,
  input  logic                 cand_ready,
  output logic signed [XW-1:0] cand_x,
  output logic signed [YW-1:0] cand_y,
  input  logic                 cost_valid,
  input  logic [CW-1:0]        cost,
  output logic signed [XW-1:0] best_x,
  output logic signed [YW-1:0] best_y,
  output logic [CW-1:0]        best_cost,
  output logic                 done
);
  localparam logic signed [XW-1:0] XMIN   = XW'(-HALF_W);
  localparam logic signed [XW-1:0] XMAX   = XW'(HALF_W - 1);
  localparam logic signed [XW-1:0] XLASTC = XW'(HALF_W - 2);
  localparam logic signed [YW-1:0] YMIN   = YW'(-HALF_H);
  localparam logic signed [YW-1:0] YMAX   = YW'(HALF_H - 1);
  localparam logic signed [YW-1:0] YLASTC = YW'(HALF_H - 2);
  localparam logic signed [XW-1:0] BLO    = XW'(BAND);
  localparam logic signed [XW-1:0] BHI    = XW'(BAND - 1);
  localparam logic signed [XW-1:0] ONE    = XW'(1);
  localparam logic signed [XW-1:0] TWO    = XW'(2);

  typedef enum logic [1:0] {IDLE, ISSUE, WAIT, SETUP} st_t;
  st_t st;
  logic signed [XW-1:0] x, cx;
  logic signed [YW-1:0] y;
  logic fine, busy, better;
  logic [XW:0] pick_cur, pick_row, pick_first;

  // earliest accepted column >= n in one row, {found, column}
  function automatic logic [XW:0] band_pick(input logic signed [XW-1:0] n,
                                            input logic odd_only,
                                            input logic signed [XW-1:0] c);
    logic signed [XW-1:0] m0, m1, lo1, hi1;
    logic v0, v1;
    lo1 = c - BLO;
    hi1 = c + BHI;
    if (hi1 > XMAX) hi1 = XMAX;
    m0 = (n > -BLO) ? n : -BLO;
    m1 = (n > lo1) ? n : lo1;
    if (odd_only) begin
      m0[0] = 1'b1;
      m1[0] = 1'b1;
    end
    v0 = (m0 <= BHI);
    v1 = (m1 <= hi1);
    if (v0 && (!v1 || m0 <= m1)) return {1'b1, m0};
    else if (v1)                 return {1'b1, m1};
    else                         return {1'b0, m0};
  endfunction

  assign busy       = (st != IDLE);
  assign better     = cost < best_cost;
  assign cand_valid = (st == ISSUE);
  assign cand_x     = x;
  assign cand_y     = y;
  assign pick_cur   = band_pick(x + (y[0] ? ONE : TWO), !y[0], cx);
  assign pick_row   = band_pick(XMIN, y[0], cx);
  assign pick_first = band_pick(XMIN, 1'b1, cx);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= IDLE; x <= '0; y <= '0; cx <= '0; fine <= 1'b0;
      best_x <= '0; best_y <= '0; best_cost <= '0; done <= 1'b0;
    end else begin
      case (st)
        IDLE: if (start) begin
          st <= ISSUE; x <= XMIN; y <= YMIN; fine <= 1'b0;
          best_cost <= '1; done <= 1'b0;
        end
        ISSUE: if (cand_ready) st <= WAIT;
        WAIT: if (cost_valid) begin
          if (better) begin
            best_cost <= cost; best_x <= x; best_y <= y;
          end
          if (!fine) begin
            if (x != XLASTC) begin
              x <= x + TWO; st <= ISSUE;
            end else if (y != YLASTC) begin
              x <= XMIN; y <= y + YW'(2); st <= ISSUE;
            end else begin
              fine <= 1'b1; st <= SETUP;
              cx <= better ? x : best_x;
            end
          end else if (pick_cur[XW]) begin
            x <= pick_cur[XW-1:0]; st <= ISSUE;
          end else if (y != YMAX) begin
            x <= pick_row[XW-1:0]; y <= y + YW'(1); st <= ISSUE;
          end else begin
            st <= IDLE; done <= 1'b1;
          end
        end
        SETUP: begin
          x <= pick_first[XW-1:0]; y <= YMIN; st <= ISSUE;
        end
        default: st <= IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cfs_checker.sv
module cfs_checker #(
  parameter int HALF_W = 96,
  parameter int HALF_H = 64,
  parameter int BAND   = 32,
  parameter int CW     = 16,
  localparam int XW = $clog2(HALF_W + BAND) + 2,
  localparam int YW = $clog2(HALF_H) + 2
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 start,
  input logic                 cand_valid,
  input logic                 cand_ready,
  input logic signed [XW-1:0] cand_x,
  input logic signed [YW-1:0] cand_y,
  input logic                 cost_valid,
  input logic [CW-1:0]        best_cost,
  input logic                 done,
  input logic                 fine,
  input logic signed [XW-1:0] cx,
  input logic                 busy
);
  logic signed [XW+1:0] dx0, dx1;
  logic in_range, in_band;
  assign dx0 = (XW+2)'(cand_x);
  assign dx1 = (XW+2)'(cand_x) - (XW+2)'(cx);
  assign in_range = (int'(cand_x) >= -HALF_W) && (int'(cand_x) < HALF_W) &&
                    (int'(cand_y) >= -HALF_H) && (int'(cand_y) < HALF_H);
  assign in_band  = (int'(dx0) >= -BAND && int'(dx0) < BAND) ||
                    (int'(dx1) >= -BAND && int'(dx1) < BAND);

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cand_valid && !cand_ready |=> cand_valid && $stable(cand_x) && $stable(cand_y));
  p_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cand_valid |-> in_range);
  p_fine_parity_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cand_valid && fine |-> (cand_x[0] || cand_y[0]));
  p_band_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cand_valid && fine |-> in_band);
  p_best_mono_r6: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) |-> best_cost <= $past(best_cost));
  p_done_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(cost_valid) && !busy);
  p_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy |=> best_cost == '1 && !done);
endmodule

bind coarse_fine_search cfs_checker #(
  .HALF_W(HALF_W), .HALF_H(HALF_H), .BAND(BAND), .CW(CW)
) u_cfs_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .cand_valid(cand_valid),
  .cand_ready(cand_ready), .cand_x(cand_x), .cand_y(cand_y),
  .cost_valid(cost_valid), .best_cost(best_cost), .done(done),
  .fine(fine), .cx(cx), .busy(busy)
);

// File: tb/test_coarse_fine_search.sv
module test_coarse_fine_search;
  localparam int CLK = 10;
  localparam int HW = 8, HH = 4, BD = 2, CW = 16;
  localparam int XW = $clog2(HW + BD) + 2;
  localparam int YW = $clog2(HH) + 2;

  logic clk = 0, rst_n = 0, start = 0, cand_ready = 0, cost_valid = 0;
  logic [CW-1:0] cost = '0;
  logic cand_valid, done;
  logic signed [XW-1:0] cand_x, best_x;
  logic signed [YW-1:0] cand_y, best_y;
  logic [CW-1:0] best_cost;

  int total = 0, bad = 0;
  int ex[256], ey[256];
  int n_exp, n_coarse, ebx, eby, ebc;

  always #(CLK/2) clk = ~clk;

  coarse_fine_search #(.HALF_W(HW), .HALF_H(HH), .BAND(BD), .CW(CW)) i_coarse_fine_search (
    .clk(clk), .rst_n(rst_n), .start(start), .cand_valid(cand_valid),
    .cand_ready(cand_ready), .cand_x(cand_x), .cand_y(cand_y),
    .cost_valid(cost_valid), .cost(cost), .best_x(best_x), .best_y(best_y),
    .best_cost(best_cost), .done(done));

  function automatic int iabs(int v); return v < 0 ? -v : v; endfunction

  function automatic int model_cost(int sc, int x, int y);
    case (sc)
      0: return 100;
      1: return iabs(x - 6) + 2 * iabs(y - 1) + 10;
      2: return ((x + 8) * 37 + (y + 4) * 11) % 23 + 5;
      3: return iabs(x + 7) + iabs(y + 3);
      default: return iabs(x - 2) + iabs(y);
    endcase
  endfunction

  task automatic check(bit ok, string req, string what, int act, int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  task automatic push(int sc, int x, int y);
    int c;
    ex[n_exp] = x; ey[n_exp] = y; n_exp++;
    c = model_cost(sc, x, y);
    if (c < ebc) begin ebc = c; ebx = x; eby = y; end
  endtask

  task automatic build(int sc);
    int cxx;
    n_exp = 0; ebc = 32'h7fffffff;
    for (int y = -HH; y < HH; y += 2)
      for (int x = -HW; x < HW; x += 2) push(sc, x, y);
    n_coarse = n_exp;
    cxx = ebx;
    for (int y = -HH; y < HH; y++)
      for (int x = -HW; x < HW; x++)
        if (!((x % 2 == 0) && (y % 2 == 0)) &&
            ((x >= -BD && x < BD) || (x - cxx >= -BD && x - cxx < BD)))
          push(sc, x, y);
  endtask

  task automatic run(int sc);
    build(sc);
    @(negedge clk) start = 1;
    @(negedge clk) start = 0;
    check(best_cost == '1, "R8", "best cost after start", best_cost, 65535);
    check(done == 0, "R8", "done after start", done, 0);
    for (int i = 0; i < n_exp; i++) begin
      int guard = 0;
      while (!cand_valid && guard < 50) begin @(negedge clk); guard++; end
      if (i < n_coarse)
        check(cand_x == ex[i] && cand_y == ey[i], "R1", "coarse cand x*1000+y",
              int'(cand_x) * 1000 + int'(cand_y), ex[i] * 1000 + ey[i]);
      else
        check(cand_x == ex[i] && cand_y == ey[i], "R4", "fine cand (R2 R3 R5) x*1000+y",
              int'(cand_x) * 1000 + int'(cand_y), ex[i] * 1000 + ey[i]);
      if (i % 3 == 1) begin
        if (i % 5 == 2) begin cost_valid = 1; cost = '0; end
        @(negedge clk) cost_valid = 0;
        @(negedge clk);
        check(cand_valid && cand_x == ex[i] && cand_y == ey[i], "R7", "hold during stall",
              int'(cand_x) * 1000 + int'(cand_y), ex[i] * 1000 + ey[i]);
      end
      cand_ready = 1;
      @(negedge clk) cand_ready = 0;
      for (int d = 0; d < i % 3; d++) @(negedge clk);
      check(!cand_valid, "R7", "no new candidate before cost", cand_valid, 0);
      cost_valid = 1; cost = CW'(model_cost(sc, ex[i], ey[i]));
      @(negedge clk) cost_valid = 0;
      if (i == n_exp - 1) check(done == 1, "R8", "done after last cost", done, 1);
      else if (i % 7 == 0) check(done == 0, "R8", "done during search", done, 0);
    end
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check(!cand_valid, "R3", "no extra candidate", cand_valid, 0);
    end
    check(done == 1, "R8", "done held", done, 1);
    check(best_x == ebx && best_y == eby, "R6", "best vector x*1000+y",
          int'(best_x) * 1000 + int'(best_y), ebx * 1000 + eby);
    check(best_cost == ebc, "R6", "best cost", best_cost, ebc);
  endtask

  initial begin
    #(CLK * 150000);
    total++; bad++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(cand_valid == 0, "R9", "cand_valid in reset", cand_valid, 0);
    check(done == 0, "R9", "done in reset", done, 0);
    rst_n = 1;
    @(negedge clk);
    check(cand_valid == 0 && done == 0, "R9", "idle after reset", cand_valid + done, 0);
    for (int sc = 0; sc < 5; sc++) run(sc);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule